// File: doc/BRIEF.md
# Multiprocessor Serial Receive and Transmit Status Controller

This block holds the status flags, control bits and interrupt requests of an asynchronous serial port that can carry address-tagged (multiprocessor) frames. The bit-level receive and transmit shifters and the baud generator sit outside it. They report to it through single-cycle event strobes. On the receive side these are start-bit seen, serial clock edge seen, and frame complete with its byte, its tag bit and its framing and parity error bits. On the transmit side they are the transmit data register taken by the shifter, and the last data bit sent. A small CPU bus reads and writes four byte registers.

The main feature is an address-wait mode. While the wait bit is set, frames whose tag bit is 0 are thrown away without any trace. The first frame whose tag bit is 1 is accepted. It records the tag in status, clears the wait bit by hardware, and from then on normal flag setting and interrupts resume. Status flags follow a read-then-clear rule: a write of 0 clears a flag only if software has read that flag as 1 since it was last set.

Register map (2-bit address, 8-bit data). Address 0 is control: bit0 receive enable, bit1 receive interrupt enable, bit2 transmit-end interrupt enable, bit3 address-wait, bit4 synchronous mode, bit5 multiprocessor format. Address 1 is status: bit0 receive-full, bit1 framing error, bit2 parity error, bit3 overrun, bit4 transmit-empty, bit5 transmit-end, bit6 tag bit (read only). Address 2 is received data (read only). Address 3 is transmit data.

Top module: `mpu_stat_top`

## Requirements
- R1: After synchronous reset, control reads 0x00, status reads 0x30 (transmit-empty and transmit-end set), received data reads 0x00 and all three interrupt outputs are low.
- R2: With address-wait set, asynchronous mode and multiprocessor format selected, a frame with tag 0 leaves received data, receive-full, framing error, parity error and overrun unchanged, and raises no interrupt.
- R3: In the same setting a frame with tag 1 is stored, sets receive-full, sets status bit6, and clears control bit3 to 0.
- R4: Address-wait has no effect in synchronous mode or with multiprocessor format off: every frame is stored and bit3 keeps its written value. Status bit6 follows the tag of stored frames only in asynchronous multiprocessor format and is 0 otherwise.
- R5: With receive enable at 0, completed frames are ignored, and clearing receive enable leaves receive-full, framing error, parity error and overrun at their previous values.
- R6: Output rx_active rises after a start-bit strobe in asynchronous mode, or after a serial clock strobe in synchronous mode, only while receive enable is 1. The other strobe has no effect. It falls after the frame-complete strobe.
- R7: When the last-bit strobe arrives while transmit-empty is 1, transmit-end is set. irq_txend is high whenever transmit-end and the transmit-end enable are both 1.
- R8: irq_txend goes low either by writing control bit2 to 0, or by reading transmit-empty as 1 then writing status bit4 to 0, which clears both transmit-empty and transmit-end. A transmit-data-taken strobe sets transmit-empty.
- R9: A write of 0 to a status flag clears it only if that flag was read as 1 since it was last set. A write of 1 has no effect.
- R10: A stored frame sets framing error and parity error from its error bits. An accepted frame that completes while receive-full is 1 sets overrun and leaves received data unchanged.
- R11: irq_rx equals receive-full AND receive interrupt enable. irq_rxerr equals (framing error OR parity error OR overrun) AND receive interrupt enable.
- R12: When a valid clear of receive-full and an accepted frame fall in the same cycle, the frame is stored, receive-full stays 1, no overrun is set, and a further clear needs a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (arms status clears) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| rx_start_bit | input | 1 | Start bit detected (asynchronous) |
| rx_sclk_edge | input | 1 | Serial clock edge seen (synchronous) |
| rx_frame_done | input | 1 | Frame complete strobe |
| rx_byte | input | 8 | Received byte |
| rx_tag | input | 1 | Multiprocessor tag bit of the frame |
| rx_frame_err | input | 1 | Stop bit missing in the frame |
| rx_parity_err | input | 1 | Parity mismatch in the frame |
| tx_load | input | 1 | Shifter took transmit data |
| tx_last_bit | input | 1 | Last data bit sent |
| tx_data | output | 8 | Transmit data register |
| rx_active | output | 1 | Reception in progress |
| irq_rx | output | 1 | Receive-full interrupt request |
| irq_rxerr | output | 1 | Receive error interrupt request |
| irq_txend | output | 1 | Transmit-end interrupt request |

## Verification
The collision that matters is a CPU clear of receive-full landing in the same cycle as a frame completion. The slot frees and refills at once, so the result must be a stored byte with no overrun and a disarmed flag. The bench provokes it by reading status, then driving the status write and the frame strobe together on one clock. It then checks received data, status, and a second clear attempt that must fail. A similar pairing is the last-bit strobe together with a transmit-empty clear. Here the clear wins, and transmit-end stays low. Around these cases, a sweep over all sixteen combinations of mode, format, wait bit and tag compares acceptance, tag status and wait-bit self-clear against values computed from R2 to R4.

// File: rtl/mpu_pkg.sv
package mpu_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_RXD  = 2'd2,
        SEL_TXD  = 2'd3
    } reg_sel_e;

    // control register, bit5 down to bit0
    typedef struct packed {
        logic mp_fmt;
        logic sync_mode;
        logic addr_wait;
        logic txend_ie;
        logic rx_ie;
        logic rx_en;
    } ctrl_t;

    // status register, bit6 down to bit0
    typedef struct packed {
        logic tag;
        logic tend;
        logic tde;
        logic ovr;
        logic pe;
        logic fe;
        logic rdf;
    } stat_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int STAT_W   = $bits(stat_t);
    localparam int RXFLAG_N = 4;   // rdf, fe, pe, ovr

    localparam int STAT_TDE_BIT = 4;

    function automatic ctrl_t unpack_ctrl(input logic [CTRL_W-1:0] d);
        return ctrl_t'(d);
    endfunction

endpackage

// File: rtl/mpu_ctrl_reg.sv
module mpu_ctrl_reg
    import mpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  ctrl_t wr_val,
    input  logic  wake,
    output ctrl_t ctrl
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl <= wr_val;
        end else if (wake) begin
            ctrl.addr_wait <= 1'b0;
        end
    end

    assert_wake_clears_wait_R3: assert property (@(posedge clk) disable iff (rst)
        (wake && !wr_en) |=> !ctrl.addr_wait);

endmodule

// File: rtl/mpu_rx_stat.sv
module mpu_rx_stat
    import mpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic                addr_wait,
    input  logic                mp_fmt,
    input  logic                sync_mode,
    input  logic                start_bit,
    input  logic                sclk_edge,
    input  logic                frame_done,
    input  logic [DATA_W-1:0]   frame_byte,
    input  logic                frame_tag,
    input  logic                frame_fe,
    input  logic                frame_pe,
    input  logic                stat_rd,
    input  logic                stat_wr,
    input  logic [RXFLAG_N-1:0] stat_wval,
    output logic [RXFLAG_N-1:0] flags,
    output logic                tag_flag,
    output logic [DATA_W-1:0]   rx_data,
    output logic                wake,
    output logic                rx_active
);

    localparam int F_RDF = 0;
    localparam int F_FE  = 1;
    localparam int F_PE  = 2;
    localparam int F_OVR = 3;

    logic                wait_live;
    logic                frame_seen;
    logic                discard;
    logic                accept;
    logic                slot_busy;
    logic                store;
    logic                overrun_evt;
    logic                begin_evt;
    logic [RXFLAG_N-1:0] arm;
    logic [RXFLAG_N-1:0] clr;
    logic [RXFLAG_N-1:0] setv;

    always_comb begin
        wait_live   = addr_wait & mp_fmt & ~sync_mode;
        frame_seen  = frame_done & rx_en;
        discard     = frame_seen & wait_live & ~frame_tag;
        accept      = frame_seen & ~discard;
        wake        = accept & wait_live;
        clr         = {RXFLAG_N{stat_wr}} & arm & ~stat_wval;
        slot_busy   = flags[F_RDF] & ~clr[F_RDF];
        store       = accept & ~slot_busy;
        overrun_evt = accept & slot_busy;
        setv        = '0;
        setv[F_RDF] = store;
        setv[F_FE]  = store & frame_fe;
        setv[F_PE]  = store & frame_pe;
        setv[F_OVR] = overrun_evt;
        begin_evt   = sync_mode ? sclk_edge : start_bit;
    end

    for (genvar i = 0; i < RXFLAG_N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
                arm[i]   <= 1'b0;
            end else if (setv[i]) begin
                flags[i] <= 1'b1;
                arm[i]   <= 1'b0;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
                arm[i]   <= 1'b0;
            end else if (stat_rd) begin
                arm[i]   <= flags[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_data   <= '0;
            tag_flag  <= 1'b0;
            rx_active <= 1'b0;
        end else begin
            if (store) begin
                rx_data <= frame_byte;
            end
            if (accept) begin
                tag_flag <= frame_tag & mp_fmt & ~sync_mode;
            end
            if (!rx_en || frame_done) begin
                rx_active <= 1'b0;
            end else if (begin_evt) begin
                rx_active <= 1'b1;
            end
        end
    end

    assert_discard_leaves_state_R2: assert property (@(posedge clk) disable iff (rst)
        (discard && !stat_wr) |=> ($stable(flags) && $stable(rx_data)));

    assert_disabled_keeps_flags_R5: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !stat_wr) |=> $stable(flags));

    assert_idle_when_disabled_R6: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !rx_active);

    assert_overrun_keeps_data_R10: assert property (@(posedge clk) disable iff (rst)
        (accept && flags[F_RDF] && !clr[F_RDF]) |=> (flags[F_OVR] && $stable(rx_data)));

    assert_write_one_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wval[F_RDF] && !frame_done) |=> $stable(flags[F_RDF]));

endmodule

// File: rtl/mpu_tx_stat.sv
module mpu_tx_stat (
    input  logic clk,
    input  logic rst,
    input  logic tx_load,
    input  logic tx_last_bit,
    input  logic stat_rd,
    input  logic stat_wr,
    input  logic tde_wval,
    output logic tde,
    output logic tend
);

    logic tde_arm;
    logic tde_clr;
    logic tde_nxt;

    always_comb begin
        tde_clr = stat_wr & tde_arm & ~tde_wval;
        if (tx_load) begin
            tde_nxt = 1'b1;
        end else if (tde_clr) begin
            tde_nxt = 1'b0;
        end else begin
            tde_nxt = tde;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tde     <= 1'b1;
            tend    <= 1'b1;
            tde_arm <= 1'b0;
        end else begin
            tde <= tde_nxt;
            if (tx_last_bit && tde_nxt) begin
                tend <= 1'b1;
            end else if (tde_clr) begin
                tend <= 1'b0;
            end
            if (tx_load || tde_clr) begin
                tde_arm <= 1'b0;
            end else if (stat_rd) begin
                tde_arm <= tde;
            end
        end
    end

    assert_tend_on_last_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_last_bit && tde && !tde_clr) |=> tend);

    assert_clear_drops_both_R8: assert property (@(posedge clk) disable iff (rst)
        (tde_clr && !tx_load) |=> (!tde && !tend));

endmodule

// File: rtl/mpu_stat_top.sv
module mpu_stat_top
    import mpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic                  rx_start_bit,
    input  logic                  rx_sclk_edge,
    input  logic                  rx_frame_done,
    input  logic [DATA_W-1:0]     rx_byte,
    input  logic                  rx_tag,
    input  logic                  rx_frame_err,
    input  logic                  rx_parity_err,
    input  logic                  tx_load,
    input  logic                  tx_last_bit,
    output logic [DATA_W-1:0]     tx_data,
    output logic                  rx_active,
    output logic                  irq_rx,
    output logic                  irq_rxerr,
    output logic                  irq_txend
);

    reg_sel_e            sel;
    ctrl_t               ctrl;
    stat_t               stat;
    logic                ctrl_wr;
    logic                stat_wr;
    logic                stat_rd;
    logic                txd_wr;
    logic                wake;
    logic [RXFLAG_N-1:0] rx_flags;
    logic                tag_flag;
    logic [DATA_W-1:0]   rx_data;
    logic                tde;
    logic                tend;

    always_comb begin
        sel     = reg_sel_e'(bus_addr);
        ctrl_wr = bus_wr & (sel == SEL_CTRL);
        stat_wr = bus_wr & (sel == SEL_STAT);
        txd_wr  = bus_wr & (sel == SEL_TXD);
        stat_rd = bus_rd & (sel == SEL_STAT);
    end

    mpu_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ctrl_wr),
        .wr_val (unpack_ctrl(bus_wdata[CTRL_W-1:0])),
        .wake   (wake),
        .ctrl   (ctrl)
    );

    mpu_rx_stat #(.DATA_W(DATA_W)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (ctrl.rx_en),
        .addr_wait  (ctrl.addr_wait),
        .mp_fmt     (ctrl.mp_fmt),
        .sync_mode  (ctrl.sync_mode),
        .start_bit  (rx_start_bit),
        .sclk_edge  (rx_sclk_edge),
        .frame_done (rx_frame_done),
        .frame_byte (rx_byte),
        .frame_tag  (rx_tag),
        .frame_fe   (rx_frame_err),
        .frame_pe   (rx_parity_err),
        .stat_rd    (stat_rd),
        .stat_wr    (stat_wr),
        .stat_wval  (bus_wdata[RXFLAG_N-1:0]),
        .flags      (rx_flags),
        .tag_flag   (tag_flag),
        .rx_data    (rx_data),
        .wake       (wake),
        .rx_active  (rx_active)
    );

    mpu_tx_stat u_tx (
        .clk         (clk),
        .rst         (rst),
        .tx_load     (tx_load),
        .tx_last_bit (tx_last_bit),
        .stat_rd     (stat_rd),
        .stat_wr     (stat_wr),
        .tde_wval    (bus_wdata[STAT_TDE_BIT]),
        .tde         (tde),
        .tend        (tend)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_data <= '0;
        end else if (txd_wr) begin
            tx_data <= bus_wdata;
        end
    end

    always_comb begin
        stat.rdf  = rx_flags[0];
        stat.fe   = rx_flags[1];
        stat.pe   = rx_flags[2];
        stat.ovr  = rx_flags[3];
        stat.tde  = tde;
        stat.tend = tend;
        stat.tag  = tag_flag;
        case (sel)
            SEL_CTRL: bus_rdata = DATA_W'(ctrl);
            SEL_STAT: bus_rdata = DATA_W'(stat);
            SEL_RXD:  bus_rdata = rx_data;
            default:  bus_rdata = tx_data;
        endcase
        irq_rx    = stat.rdf & ctrl.rx_ie;
        irq_rxerr = (stat.fe | stat.pe | stat.ovr) & ctrl.rx_ie;
        irq_txend = stat.tend & ctrl.txend_ie;
    end

endmodule

// File: tb/sim_mpu_stat_top.sv
module sim_mpu_stat_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_start_bit = 1'b0, rx_sclk_edge = 1'b0, rx_frame_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_tag = 1'b0, rx_frame_err = 1'b0, rx_parity_err = 1'b0;
    logic       tx_load = 1'b0, tx_last_bit = 1'b0;
    logic [7:0] tx_data;
    logic       rx_active, irq_rx, irq_rxerr, irq_txend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpu_stat_top u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_start_bit(rx_start_bit), .rx_sclk_edge(rx_sclk_edge),
        .rx_frame_done(rx_frame_done), .rx_byte(rx_byte), .rx_tag(rx_tag),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .tx_load(tx_load), .tx_last_bit(tx_last_bit), .tx_data(tx_data),
        .rx_active(rx_active), .irq_rx(irq_rx), .irq_rxerr(irq_rxerr),
        .irq_txend(irq_txend)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic frame(input logic [7:0] b, input logic tg, input logic fe, input logic pe);
        rx_byte = b; rx_tag = tg; rx_frame_err = fe; rx_parity_err = pe;
        rx_frame_done = 1'b1;
        @(negedge clk);
        rx_frame_done = 1'b0; rx_tag = 1'b0; rx_frame_err = 1'b0; rx_parity_err = 1'b0;
    endtask

    task automatic pulse_evt(input int which);
        case (which)
            0: rx_start_bit = 1'b1;
            1: rx_sclk_edge = 1'b1;
            2: tx_load      = 1'b1;
            default: tx_last_bit = 1'b1;
        endcase
        @(negedge clk);
        rx_start_bit = 1'b0; rx_sclk_edge = 1'b0; tx_load = 1'b0; tx_last_bit = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 stat", v, 8'h30);
        rd(2'd2, v); chk("R1 rxd", v, 8'h00);
        chk("R1 irqs", {5'd0, irq_rx, irq_rxerr, irq_txend}, 8'h00);

        // R2 R3 R4 sweep: sync, format, wait, tag
        for (int c = 0; c < 16; c++) begin
            logic sy, fm, wt, tg, live, acc;
            logic [7:0] b, exp_stat, exp_ctrl;
            string tag;
            sy = c[0]; fm = c[1]; wt = c[2]; tg = c[3];
            live = !sy && fm && wt;
            acc  = !(live && !tg);
            b    = 8'(c * 17 + 5);
            tag  = live ? (tg ? "R3" : "R2") : "R4";
            do_reset();
            exp_ctrl = {2'b00, fm, sy, wt, 1'b0, 1'b1, 1'b1};
            wr(2'd0, exp_ctrl);
            frame(b, tg, 1'b0, 1'b0);
            exp_stat = {1'b0, acc && !sy && fm && tg, 2'b11, 3'b000, acc};
            rd(2'd1, v); chk({tag, " stat"}, v, exp_stat);
            rd(2'd2, v); chk({tag, " rxd"}, v, acc ? b : 8'h00);
            if (live && tg) exp_ctrl[3] = 1'b0;
            rd(2'd0, v); chk({tag, " ctrl wait bit"}, v, exp_ctrl);
            chk({tag, " irq_rx"}, {7'd0, irq_rx}, {7'd0, acc});
        end

        // R10 R11 overrun and error interrupt
        do_reset();
        wr(2'd0, 8'h03);
        frame(8'hA1, 1'b0, 1'b0, 1'b0);
        frame(8'hB2, 1'b0, 1'b0, 1'b0);
        rd(2'd1, v); chk("R10 overrun stat", v, 8'h39);
        rd(2'd2, v); chk("R10 data kept", v, 8'hA1);
        chk("R11 irq_rxerr", {6'd0, irq_rx, irq_rxerr}, 8'h03);
        wr(2'd0, 8'h01);
        chk("R11 gated off", {6'd0, irq_rx, irq_rxerr}, 8'h00);

        // R9 read-then-clear
        do_reset();
        wr(2'd0, 8'h01);
        frame(8'h44, 1'b0, 1'b0, 1'b0);
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk("R9 clear without read", v, 8'h31);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R9 write one inert", v, 8'h31);
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk("R9 clear after read", v, 8'h30);

        // R10 R11 error bits of stored frame
        do_reset();
        wr(2'd0, 8'h03);
        frame(8'h55, 1'b0, 1'b1, 1'b1);
        rd(2'd1, v); chk("R10 fe pe", v, 8'h37);
        chk("R11 irq_rxerr fe pe", {7'd0, irq_rxerr}, 8'h01);

        // R5 receive disable
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R5 flags kept", v, 8'h37);
        frame(8'h99, 1'b0, 1'b0, 1'b0);
        rd(2'd2, v); chk("R5 frame ignored", v, 8'h55);
        rd(2'd1, v); chk("R5 no overrun", v, 8'h37);

        // R6 reception start
        do_reset();
        pulse_evt(0);
        chk("R6 idle when disabled", {7'd0, rx_active}, 8'h00);
        wr(2'd0, 8'h01);
        pulse_evt(1);
        chk("R6 clock ignored async", {7'd0, rx_active}, 8'h00);
        pulse_evt(0);
        chk("R6 start async", {7'd0, rx_active}, 8'h01);
        frame(8'h01, 1'b0, 1'b0, 1'b0);
        chk("R6 ends at frame", {7'd0, rx_active}, 8'h00);
        wr(2'd0, 8'h11);
        pulse_evt(0);
        chk("R6 start ignored sync", {7'd0, rx_active}, 8'h00);
        pulse_evt(1);
        chk("R6 clock sync", {7'd0, rx_active}, 8'h01);

        // R7 R8 transmit end
        do_reset();
        wr(2'd0, 8'h04);
        chk("R7 irq at reset end", {7'd0, irq_txend}, 8'h01);
        wr(2'd0, 8'h00);
        chk("R8 enable clear", {7'd0, irq_txend}, 8'h00);
        wr(2'd0, 8'h04);
        wr(2'd3, 8'h5A);
        chk("R8 tx data", tx_data, 8'h5A);
        rd(2'd1, v);
        wr(2'd1, 8'h00);
        rd(2'd1, v); chk("R8 tde tend cleared", v, 8'h00);
        chk("R8 irq low", {7'd0, irq_txend}, 8'h00);
        pulse_evt(3);
        rd(2'd1, v); chk("R7 no end while full", v, 8'h00);
        pulse_evt(2);
        rd(2'd1, v); chk("R8 load sets tde", v, 8'h10);
        pulse_evt(3);
        rd(2'd1, v); chk("R7 end set", v, 8'h30);
        chk("R7 irq high", {7'd0, irq_txend}, 8'h01);

        // R12 clear and frame in one cycle
        do_reset();
        wr(2'd0, 8'h01);
        frame(8'h11, 1'b0, 1'b0, 1'b0);
        rd(2'd1, v);
        bus_addr = 2'd1; bus_wdata = 8'h10; bus_wr = 1'b1;
        rx_byte = 8'h22; rx_frame_done = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; rx_frame_done = 1'b0;
        rd(2'd2, v); chk("R12 new byte stored", v, 8'h22);
        wr(2'd1, 8'h10);
        rd(2'd1, v); chk("R12 no overrun and disarmed", v, 8'h31);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule